// File: doc/BRIEF.md
# Configurable ADC Serial Output Formatter

This block takes parallel conversion samples and sends each one as a serial word on one data line. With each word it gives a frame marker that shows where words begin and end, and a data-clock indicator whose phase against the data edge can be set. The model works at the resolution of sub-bit ticks. Each bit slot lasts `TICKS_PER_SLOT` clock cycles. With the default of twelve, one tick is 30 degrees of a bit period.

A sample is captured whenever `sample_valid_i` is high. At each word boundary the most recently captured sample is loaded, together with the word length, bit order, inversion and data-clock phase controls. Settings changed during a word therefore reach the line only when the next word starts, and no partial word is ever emitted. If no new sample arrives before a boundary, the previous word is sent again.

Top module: `serial_word_formatter`

## Requirements
- R1: While reset is held and during the first word after reset, the settings are the defaults: 14-bit word, MSB first, no inversion, data-clock phase code 0. The loaded word is all zeros, so `dout_o` is 0, `frame_o` is 1 and `dclk_o` is 0 at tick 0.
- R2: With length code 0 the word carries all 14 sample bits, sent from bit 13 down to bit 0.
- R3: Length code `len_code_i` selects the word length as 14 - 2*code (0:14, 1:12, 2:10, 3:8 slots). The upper bits of the sample are kept and the lower bits are dropped. The next word starts exactly after that many slots.
- R4: When `lsb_first_i` is 1, the kept bits are sent in reverse order, starting with the lowest kept bit (sample bit 14 - length).
- R5: When `invert_i` is 1, every data bit is complemented. This works independently of bit order and length.
- R6: `frame_o` is 1 during the first length/2 slots of each word and 0 during the rest, so it rises only at the first tick of a word.
- R7: Each bit slot lasts `TICKS_PER_SLOT` ticks, and `dout_o` does not change inside a slot.
- R8: With phase code 0, `dclk_o` rises 90 degrees (3 of 12 ticks) after the slot's data edge and stays high for half a slot.
- R9: Each step of `phase_code_i` moves the rising edge of `dclk_o` 60 degrees (2 ticks) later, modulo one slot. Codes 6 and 7 give the same phase as codes 0 and 1.
- R10: Length, order, inversion and phase are applied only at a word boundary. A change made during a word does not alter that word.
- R11: A word carries the last sample captured before its boundary. With no new valid strobe, the previous sample is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, `TICKS_PER_SLOT` cycles per bit slot |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 14 | Parallel conversion sample |
| sample_valid_i | input | 1 | Capture strobe for `sample_i` |
| len_code_i | input | 2 | Word length code (14 - 2*code bits) |
| lsb_first_i | input | 1 | 1 sends the lowest kept bit first |
| invert_i | input | 1 | 1 complements every data bit |
| phase_code_i | input | 3 | Data-clock phase, 90 + 60*code degrees |
| dout_o | output | 1 | Serial data bit |
| frame_o | output | 1 | Frame marker, high for the first half of a word |
| dclk_o | output | 1 | Data-clock phase indicator |

## Verification
The main stimulus is a table of eight samples with different bit patterns. It covers every length code, both bit orders, both polarities and all eight phase codes. Lengths are told apart by the slot where the frame marker falls and the slot where the next word begins. Order and polarity are told apart by asymmetric samples, whose reversed or complemented words differ from the plain word in known slots. Each phase code is checked on all twelve ticks of the first slot, so an error of one tick is visible. Directed cases cover the reset word, a word that repeats when no strobe arrives, and settings and a new sample applied in the middle of a word, which must show up only in the following word.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

  typedef struct packed {
    logic [1:0] len_code;
    logic       lsb_first;
    logic       invert;
    logic [2:0] phase;
  } fmt_cfg_t;

  // Word length in slots for a length code.
  function automatic int unsigned word_len(int unsigned sample_w, int unsigned code);
    return sample_w - 2 * code;
  endfunction

  // Tick on which the data-clock indicator rises: 90 deg plus 60 deg per code.
  function automatic int unsigned clk_offset(int unsigned ticks, int unsigned code);
    return (ticks / 4 + code * (ticks / 6)) % ticks;
  endfunction

  // Sample bit sent in a given slot.
  function automatic int unsigned bit_index(int unsigned sample_w, int unsigned len,
                                            bit lsb_first, int unsigned slot);
    if (lsb_first) return sample_w - len + slot;
    return sample_w - 1 - slot;
  endfunction

endpackage

// File: rtl/sfmt_slot_timer.sv
module sfmt_slot_timer #(
  parameter int TICKS = 12,
  parameter int TICK_W = 4,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  len,
  output logic [TICK_W-1:0] tick_q,
  output logic [CNT_W-1:0]  slot_q,
  output logic              word_end
);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS - 1);

  logic slot_end;
  assign slot_end = (tick_q == LAST_TICK);
  assign word_end = slot_end && (slot_q == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
    end else if (slot_end) begin
      tick_q <= '0;
      slot_q <= word_end ? '0 : slot_q + CNT_W'(1);
    end else begin
      tick_q <= tick_q + TICK_W'(1);
    end
  end
endmodule

// File: rtl/sfmt_word_latch.sv
module sfmt_word_latch #(
  parameter int SAMPLE_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SAMPLE_W-1:0]  sample_i,
  input  logic                 valid_i,
  input  sfmt_pkg::fmt_cfg_t   cfg_i,
  input  logic                 word_end,
  output logic [SAMPLE_W-1:0]  word_q,
  output sfmt_pkg::fmt_cfg_t   cfg_q
);
  logic [SAMPLE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (valid_i) hold_q <= sample_i;
      if (word_end) begin
        word_q <= valid_i ? sample_i : hold_q;
        cfg_q  <= cfg_i;
      end
    end
  end
endmodule

// File: rtl/sfmt_line_decode.sv
module sfmt_line_decode #(
  parameter int SAMPLE_W = 14,
  parameter int TICKS = 12,
  parameter int TICK_W = 4,
  parameter int CNT_W = 4
) (
  input  logic [SAMPLE_W-1:0] word,
  input  logic                lsb_first,
  input  logic                invert,
  input  logic [CNT_W-1:0]    len,
  input  logic [TICK_W-1:0]   off,
  input  logic [CNT_W-1:0]    slot,
  input  logic [TICK_W-1:0]   tick,
  output logic                dout_o,
  output logic                frame_o,
  output logic                dclk_o
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [IDX_W-1:0] idx;
  int unsigned      rel;

  always_comb begin
    idx     = IDX_W'(sfmt_pkg::bit_index(SAMPLE_W, 32'(len), lsb_first, 32'(slot)));
    dout_o  = word[idx] ^ invert;
    frame_o = (32'(slot) < (32'(len) / 2));
    rel     = (32'(tick) + TICKS - 32'(off)) % TICKS;
    dclk_o  = (rel < TICKS / 2);
  end
endmodule

// File: rtl/serial_word_formatter.sv
module serial_word_formatter #(
  parameter int SAMPLE_W = 14,
  parameter int TICKS_PER_SLOT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [1:0]          len_code_i,
  input  logic                lsb_first_i,
  input  logic                invert_i,
  input  logic [2:0]          phase_code_i,
  output logic                dout_o,
  output logic                frame_o,
  output logic                dclk_o
);
  localparam int TICK_W = $clog2(TICKS_PER_SLOT);
  localparam int CNT_W  = $clog2(SAMPLE_W + 1);

  sfmt_pkg::fmt_cfg_t  cfg_in;
  sfmt_pkg::fmt_cfg_t  cfg_act;
  logic [SAMPLE_W-1:0] word_act;
  logic [TICK_W-1:0]   tick_q;
  logic [CNT_W-1:0]    slot_q;
  logic                word_end;
  logic [CNT_W-1:0]    len_act;
  logic [TICK_W-1:0]   off_act;

  assign cfg_in  = '{len_code: len_code_i, lsb_first: lsb_first_i,
                     invert: invert_i, phase: phase_code_i};
  assign len_act = CNT_W'(sfmt_pkg::word_len(SAMPLE_W, 32'(cfg_act.len_code)));
  assign off_act = TICK_W'(sfmt_pkg::clk_offset(TICKS_PER_SLOT, 32'(cfg_act.phase)));

  sfmt_slot_timer #(.TICKS(TICKS_PER_SLOT), .TICK_W(TICK_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .len(len_act),
    .tick_q(tick_q), .slot_q(slot_q), .word_end(word_end)
  );

  sfmt_word_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .valid_i(sample_valid_i),
    .cfg_i(cfg_in), .word_end(word_end), .word_q(word_act), .cfg_q(cfg_act)
  );

  sfmt_line_decode #(.SAMPLE_W(SAMPLE_W), .TICKS(TICKS_PER_SLOT),
                     .TICK_W(TICK_W), .CNT_W(CNT_W)) u_decode (
    .word(word_act), .lsb_first(cfg_act.lsb_first), .invert(cfg_act.invert),
    .len(len_act), .off(off_act), .slot(slot_q), .tick(tick_q),
    .dout_o(dout_o), .frame_o(frame_o), .dclk_o(dclk_o)
  );
endmodule

// File: rtl/sfmt_checker.sv
module sfmt_checker #(
  parameter int TICK_W = 4,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TICK_W-1:0] tick_q,
  input logic [CNT_W-1:0]  slot_q,
  input logic              word_end,
  input logic [CNT_W-1:0]  len_act,
  input logic [TICK_W-1:0] off_act,
  input logic              dout_o,
  input logic              frame_o,
  input logic              dclk_o
);
  assert_word_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (slot_q == '0 && tick_q == '0));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end |=> ($stable(len_act) && $stable(off_act)));

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < len_act);

  assert_bit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q != '0) |-> $stable(dout_o));

  assert_frame_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> (slot_q == '0 && tick_q == '0));

  assert_dclk_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dclk_o) && tick_q != '0) |-> (tick_q == off_act));
endmodule

bind serial_word_formatter sfmt_checker #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .slot_q(slot_q), .word_end(word_end),
  .len_act(len_act), .off_act(off_act), .dout_o(dout_o), .frame_o(frame_o),
  .dclk_o(dclk_o)
);

// File: tb/tb_serial_word_formatter.sv
module tb_serial_word_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 12;
  localparam int NVEC = 8;
  // {sample[13:0], len_code[1:0], lsb_first, invert, phase[2:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {14'h2A5C, 2'd0, 1'b0, 1'b0, 3'd0},
    {14'h1357, 2'd1, 1'b0, 1'b0, 3'd1},
    {14'h3F01, 2'd2, 1'b0, 1'b0, 3'd2},
    {14'h0F0F, 2'd3, 1'b0, 1'b0, 3'd3},
    {14'h2A5C, 2'd0, 1'b1, 1'b0, 3'd4},
    {14'h1357, 2'd3, 1'b1, 1'b0, 3'd5},
    {14'h3001, 2'd0, 1'b0, 1'b1, 3'd6},
    {14'h1234, 2'd2, 1'b1, 1'b1, 3'd7}
  };

  logic clk = 0, rst_n = 0;
  logic [13:0] sample = '0;
  logic valid = 0, lsb = 0, inv = 0;
  logic [1:0] lcode = '0;
  logic [2:0] ph = '0;
  logic dout, frame, dclk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_formatter dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .len_code_i(lcode), .lsb_first_i(lsb), .invert_i(inv), .phase_code_i(ph),
    .dout_o(dout), .frame_o(frame), .dclk_o(dclk)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic bit ref_bit(logic [13:0] smp, int len, bit lsbf, bit invf, int s);
    logic [13:0] kept;
    int pos;
    kept = smp >> (14 - len);
    pos = lsbf ? s : len - 1 - s;
    return kept[pos] ^ invf;
  endfunction

  function automatic bit ref_dclk(int code, int t);
    int r;
    r = (3 + 2 * (code % 6)) % 12;
    return (t >= r && t < r + 6) || (t + 12 < r + 6);
  endfunction

  function automatic void drive_vec(logic [20:0] v);
    {sample, lcode, lsb, inv, ph} = v;
    valid = 1;
  endfunction

  // Called at the negedge of tick 0 of a word; returns at tick 0 of the next.
  task automatic check_word(input logic [13:0] smp, input logic [1:0] lc, input bit lsbf,
                            input bit invf, input logic [2:0] pc, input bit mid,
                            input string tag);
    int len;
    len = 14 - 2 * int'(lc);
    for (int c = 0; c < len * TPS; c++) begin
      int s, t;
      s = c / TPS;
      t = c % TPS;
      if (c == 1) valid = 0;
      if (mid && c == 30) begin
        lcode = 2'd3; lsb = 0; inv = 0; ph = 3'd0;  // R10 mid-word change
        sample = 14'h3C3C; valid = 1;
      end
      if (mid && c == 31) valid = 0;
      if (s == 0)
        chk(dclk == ref_dclk(int'(pc), t), $sformatf("R8 R9 dclk %s tick %0d", tag, t),
            int'(dclk), int'(ref_dclk(int'(pc), t)));
      if (t == 6) begin
        chk(dout == ref_bit(smp, len, lsbf, invf, s),
            $sformatf("R2 R3 R4 R5 data %s slot %0d", tag, s),
            int'(dout), int'(ref_bit(smp, len, lsbf, invf, s)));
        chk(frame == (s < len / 2), $sformatf("R6 frame %s slot %0d", tag, s),
            int'(frame), int'(s < len / 2));
      end
      if (t == 1 || t == 11)
        chk(dout == ref_bit(smp, len, lsbf, invf, s),
            $sformatf("R7 slot hold %s slot %0d tick %0d", tag, s, t),
            int'(dout), int'(ref_bit(smp, len, lsbf, invf, s)));
      @(negedge clk);
    end
    chk(frame == 1'b1, $sformatf("R3 R7 next word start %s", tag), int'(frame), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout == 0, "R1 reset dout", int'(dout), 0);
    chk(frame == 1, "R1 reset frame", int'(frame), 1);
    chk(dclk == 0, "R1 reset dclk", int'(dclk), 0);
    rst_n = 1;
    drive_vec(VEC[0]);
    check_word(14'h0, 2'd0, 0, 0, 3'd0, 0, "R1 first word");
    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] s_e; logic [1:0] l_e; logic b_e, i_e; logic [2:0] p_e;
      {s_e, l_e, b_e, i_e, p_e} = VEC[i];
      if (i < NVEC - 1) drive_vec(VEC[i+1]);
      check_word(s_e, l_e, b_e, i_e, p_e, 0, $sformatf("vec %0d", i));
    end
    // R11: no strobe, previous word repeats
    check_word(14'h1234, 2'd2, 1, 1, 3'd7, 0, "R11 repeat");
    // R10: change everything mid-word; this word unchanged
    check_word(14'h1234, 2'd2, 1, 1, 3'd7, 1, "R10 mid change");
    // R10 R11: new settings and sample appear in the following word
    check_word(14'h3C3C, 2'd3, 0, 0, 3'd0, 0, "R10 after change");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule